// File: doc/BRIEF.md
# Multi-CPU Bank-Switching Memory Translator

This block sits between four CPUs, each with a 16-bit logical address space, and one shared physical memory built from 512 KiB superblocks. Each CPU owns a private set of bank registers for every addressing mode it supports. A CPU in standard mode sees its 64 KiB space as eight 8 KiB windows. The top two bits of each window's block number pick one of four superblocks from a fixed table for that CPU. CPU0 and CPU1 also have an extended mode. In extended mode the low 32 KiB still uses four 8 KiB windows, and the high 32 KiB is served by larger linear blocks: one 32 KiB window for CPU0, two 16 KiB windows for CPU1.

Software loads the bank registers and mode bits through one shared configuration write port. Every CPU has its own request port. One clock after a request, the block returns a registered physical address, a qualified write strobe and a fault flag for that CPU. The block protects one 8 KiB physical page, the top page of the all-shared superblock. Only CPU0 may write that page. A write to it from any other CPU is blocked and raises a fault.

Top module: `bank_mmu`

## Requirements
- R1: After synchronous reset, standard register n of every CPU holds block 56+n, every extended register holds 0, every CPU is in standard mode, and all outputs are low.
- R2: In standard mode, window w = addr[15:13] uses block b from standard register w. The result is phys = S*2^19 + b[5:0]*2^13 + addr[12:0], where S comes from b[7:6]. For b[7:6]=0,1,2 the table gives CPU0→0,1,2; CPU1→4,5,1; CPU2→6,5,7; CPU3→8,7,2.
- R3: Blocks 192 to 255 (b[7:6]=3) resolve to superblock index 3 for every CPU, so the same block number and offset give the same physical address from any CPU.
- R4: A write request whose physical address falls in page 255 (0x1FE000–0x1FFFFF) and comes from CPU1, CPU2 or CPU3 returns phy_write=0 and fault=1. A read of that page, or a write to it from CPU0, never faults.
- R5: In CPU0 extended mode, extended registers 0–3 map the low four windows using the R2 decode. Extended register 4 maps 0x8000–0xFFFF as phys = b*2^15 + addr[14:0].
- R6: In CPU1 extended mode, extended registers 0–3 map the low windows using the R2 decode. Register 4 serves 0x8000–0xBFFF and register 5 serves 0xC000–0xFFFF, each as phys = b*2^14 + addr[13:0].
- R7: Configuration selector cfg_ext=0 writes a standard register and cfg_ext=1 writes an extended register. The two sets are independent, so changing mode in either direction restores the other set's earlier mapping unchanged.
- R8: A mode write that asks CPU2 or CPU3 to enter extended mode is ignored, and those CPUs keep translating in standard mode.
- R9: Outputs appear one clock after the request. A configuration write on the same edge as a request affects only later requests.
- R10: phy_valid repeats req_valid one clock later, and phy_write equals the delayed req_write masked by the fault flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Bank register write strobe |
| cfg_cpu | input | 2 | Target CPU of the register write |
| cfg_ext | input | 1 | 0 selects a standard register, 1 an extended register |
| cfg_idx | input | 3 | Register index within the selected set |
| cfg_blk | input | 8 | Block number to store |
| mode_we | input | 1 | Mode write strobe |
| mode_cpu | input | 2 | Target CPU of the mode write |
| mode_ext | input | 1 | 1 requests extended mode, 0 standard mode |
| req_valid | input | 4 | Per-CPU request valid |
| req_write | input | 4 | Per-CPU request is a write |
| req_addr | input | 64 | Per-CPU 16-bit logical address, CPU n in bits [16n+15:16n] |
| phy_valid | output | 4 | Per-CPU registered result valid |
| phy_write | output | 4 | Per-CPU permitted write strobe |
| phy_addr | output | 92 | Per-CPU 23-bit physical address, CPU n in bits [23n+22:23n] |
| fault | output | 4 | Per-CPU one-cycle protection fault |

## Verification
Every result of this block is due exactly one clock after the request that caused it. That includes the physical address, the qualified write strobe and the fault flag. A configuration or mode write changes translation only for requests presented after the edge that stores it. The bench drives all inputs on the falling edge and works out the expected outputs from its own model state before the rising edge. It updates that model at the rising edge and compares the outputs at the next falling edge. This keeps each comparison one register stage behind its stimulus, including the case where a register write and a request share an edge.

// File: rtl/bank_mmu_pkg.sv
package bank_mmu_pkg;

  // physical superblock slots, 512 KiB each
  typedef enum logic [3:0] {
    SB_A = 4'd0, SB_B = 4'd1, SB_C = 4'd2, SB_D = 4'd3,
    SB_E = 4'd4, SB_F = 4'd5, SB_G = 4'd6, SB_H = 4'd7,
    SB_K = 4'd8
  } sb_e;

  // shape of the upper half in extended mode
  typedef enum logic [1:0] {
    HI_NONE  = 2'd0,
    HI_ONE32 = 2'd1,
    HI_TWO16 = 2'd2
  } hi_kind_e;

  function automatic hi_kind_e hi_kind(input int cpu);
    case (cpu)
      0:       return HI_ONE32;
      1:       return HI_TWO16;
      default: return HI_NONE;
    endcase
  endfunction

  // registers in the extended set (low windows plus high windows)
  function automatic int ext_count(input int cpu);
    case (hi_kind(cpu))
      HI_ONE32: return 5;
      HI_TWO16: return 6;
      default:  return 0;
    endcase
  endfunction

  // quadrant of the block number -> superblock, per CPU
  function automatic sb_e sb_lookup(input int cpu, input logic [1:0] quad);
    if (quad == 2'd3) return SB_D;
    case (cpu)
      0: case (quad) 2'd0: return SB_A; 2'd1: return SB_B; default: return SB_C; endcase
      1: case (quad) 2'd0: return SB_E; 2'd1: return SB_F; default: return SB_B; endcase
      2: case (quad) 2'd0: return SB_G; 2'd1: return SB_F; default: return SB_H; endcase
      default: case (quad) 2'd0: return SB_K; 2'd1: return SB_H; default: return SB_C; endcase
    endcase
  endfunction

endpackage

// File: rtl/bank_mmu_regs.sv
module bank_mmu_regs
  import bank_mmu_pkg::*;
#(
  parameter int CPU_ID   = 0,
  parameter int BLK_W    = 8,
  parameter int IDX_W    = 3,
  parameter int RST_BASE = 56
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_ext,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [BLK_W-1:0] wr_blk,
  input  logic             md_en,
  input  logic             md_ext,
  output logic [BLK_W-1:0] std_q [2**IDX_W],
  output logic [BLK_W-1:0] ext_q [2**IDX_W],
  output logic             ext_mode
);
  localparam int NWIN    = 2**IDX_W;
  localparam int EXT_CNT = ext_count(CPU_ID);
  localparam bit HAS_EXT = (EXT_CNT != 0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int n = 0; n < NWIN; n++) begin
        std_q[n] <= BLK_W'(RST_BASE + n);
        ext_q[n] <= '0;
      end
      ext_mode <= 1'b0;
    end else begin
      if (wr_en && !wr_ext) std_q[wr_idx] <= wr_blk;
      if (wr_en && wr_ext && HAS_EXT && (int'(wr_idx) < EXT_CNT))
        ext_q[wr_idx] <= wr_blk;
      if (md_en) ext_mode <= md_ext && HAS_EXT;
    end
  end

endmodule

// File: rtl/bank_mmu_xlate.sv
module bank_mmu_xlate
  import bank_mmu_pkg::*;
#(
  parameter int CPU_ID = 0,
  parameter int LA_W   = 16,
  parameter int BLK_W  = 8,
  parameter int IDX_W  = 3,
  parameter int PA_W   = 23
) (
  input  logic [LA_W-1:0]  addr,
  input  logic [BLK_W-1:0] std_q [2**IDX_W],
  input  logic [BLK_W-1:0] ext_q [2**IDX_W],
  input  logic             ext_mode,
  output logic [PA_W-1:0]  pa
);
  localparam int       OFF_W = LA_W - IDX_W;   // 8 KiB offset bits
  localparam int       SUB_W = BLK_W - 2;      // block within superblock
  localparam hi_kind_e KIND  = hi_kind(CPU_ID);

  logic [IDX_W-1:0] win;
  logic [BLK_W-1:0] blk;
  logic             hi_half;

  assign win     = addr[LA_W-1 -: IDX_W];
  assign hi_half = addr[LA_W-1];

  always_comb begin
    blk = ext_mode ? ext_q[win] : std_q[win];
    pa  = PA_W'({sb_lookup(CPU_ID, blk[BLK_W-1 -: 2]), blk[SUB_W-1:0], addr[OFF_W-1:0]});
    if (ext_mode && hi_half) begin
      if (KIND == HI_ONE32) begin
        pa = PA_W'({ext_q[4], addr[LA_W-2:0]});
      end else if (KIND == HI_TWO16) begin
        pa = PA_W'({(addr[LA_W-2] ? ext_q[5] : ext_q[4]), addr[LA_W-3:0]});
      end
    end
  end

endmodule

// File: rtl/bank_mmu.sv
module bank_mmu
  import bank_mmu_pkg::*;
#(
  parameter int NCPU      = 4,
  parameter int LA_W      = 16,
  parameter int BLK_W     = 8,
  parameter int PA_W      = 23,
  parameter int GUARD_PG  = 255,
  parameter int RST_BASE  = 56
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_we,
  input  logic [1:0]             cfg_cpu,
  input  logic                   cfg_ext,
  input  logic [2:0]             cfg_idx,
  input  logic [BLK_W-1:0]       cfg_blk,
  input  logic                   mode_we,
  input  logic [1:0]             mode_cpu,
  input  logic                   mode_ext,
  input  logic [NCPU-1:0]        req_valid,
  input  logic [NCPU-1:0]        req_write,
  input  logic [NCPU*LA_W-1:0]   req_addr,
  output logic [NCPU-1:0]        phy_valid,
  output logic [NCPU-1:0]        phy_write,
  output logic [NCPU*PA_W-1:0]   phy_addr,
  output logic [NCPU-1:0]        fault
);
  localparam int IDX_W = 3;
  localparam int NWIN  = 2**IDX_W;
  localparam int OFF_W = LA_W - IDX_W;
  localparam int PG_W  = PA_W - OFF_W;

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic [BLK_W-1:0] std_q [NWIN];
    logic [BLK_W-1:0] ext_q [NWIN];
    logic             ext_mode;
    logic [PA_W-1:0]  pa;
    logic             guard_hit;
    logic             v_q, w_q, f_q;
    logic [PA_W-1:0]  a_q;

    bank_mmu_regs #(
      .CPU_ID(c), .BLK_W(BLK_W), .IDX_W(IDX_W), .RST_BASE(RST_BASE)
    ) u_regs (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (cfg_we && (cfg_cpu == 2'(c))),
      .wr_ext   (cfg_ext),
      .wr_idx   (cfg_idx),
      .wr_blk   (cfg_blk),
      .md_en    (mode_we && (mode_cpu == 2'(c))),
      .md_ext   (mode_ext),
      .std_q    (std_q),
      .ext_q    (ext_q),
      .ext_mode (ext_mode)
    );

    bank_mmu_xlate #(
      .CPU_ID(c), .LA_W(LA_W), .BLK_W(BLK_W), .IDX_W(IDX_W), .PA_W(PA_W)
    ) u_xlate (
      .addr     (req_addr[c*LA_W +: LA_W]),
      .std_q    (std_q),
      .ext_q    (ext_q),
      .ext_mode (ext_mode),
      .pa       (pa)
    );

    // system page: writable by CPU0 only
    if (c == 0) begin : g_master
      assign guard_hit = 1'b0;
    end else begin : g_guest
      assign guard_hit = (pa[PA_W-1 -: PG_W] == PG_W'(GUARD_PG));
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= 1'b0;
        w_q <= 1'b0;
        f_q <= 1'b0;
        a_q <= '0;
      end else begin
        v_q <= req_valid[c];
        w_q <= req_valid[c] && req_write[c] && !guard_hit;
        f_q <= req_valid[c] && req_write[c] && guard_hit;
        a_q <= pa;
      end
    end

    assign phy_valid[c]                = v_q;
    assign phy_write[c]                = w_q;
    assign fault[c]                    = f_q;
    assign phy_addr[c*PA_W +: PA_W]    = a_q;
  end

endmodule

// File: rtl/bank_mmu_chk.sv
module bank_mmu_chk #(
  parameter int NCPU  = 4,
  parameter int LA_W  = 16,
  parameter int PA_W  = 23
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NCPU-1:0]      req_valid,
  input logic [NCPU-1:0]      req_write,
  input logic [NCPU*LA_W-1:0] req_addr,
  input logic [NCPU-1:0]      phy_valid,
  input logic [NCPU-1:0]      phy_write,
  input logic [NCPU*PA_W-1:0] phy_addr,
  input logic [NCPU-1:0]      fault
);
  localparam int OFF_W = LA_W - 3;

  // R4
  master_nofault_chk: assert property (@(posedge clk) disable iff (rst)
    !fault[0]);

  for (genvar c = 0; c < NCPU; c++) begin : g_chk
    // R10
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
      req_valid[c] |=> phy_valid[c]);
    // R10
    vld_source_chk: assert property (@(posedge clk) disable iff (rst)
      phy_valid[c] |-> $past(req_valid[c]));
    // R4
    fault_cause_chk: assert property (@(posedge clk) disable iff (rst)
      fault[c] |-> $past(req_valid[c] && req_write[c]));
    // R4
    fault_block_chk: assert property (@(posedge clk) disable iff (rst)
      fault[c] |-> !phy_write[c]);
    // R10
    write_source_chk: assert property (@(posedge clk) disable iff (rst)
      phy_write[c] |-> $past(req_valid[c] && req_write[c]));
    // R2
    offset_keep_chk: assert property (@(posedge clk) disable iff (rst)
      phy_valid[c] |-> (phy_addr[c*PA_W +: OFF_W] == $past(req_addr[c*LA_W +: OFF_W])));
  end

endmodule

bind bank_mmu bank_mmu_chk #(.NCPU(NCPU), .LA_W(LA_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .phy_valid(phy_valid), .phy_write(phy_write),
  .phy_addr(phy_addr), .fault(fault)
);

// File: tb/bank_mmu_tb.sv
`timescale 1ns/1ps
module bank_mmu_tb;
  localparam int NC = 4;
  localparam int LW = 16;
  localparam int PW = 23;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 0, cfg_ext = 0, mode_we = 0, mode_ext = 0;
  logic [1:0] cfg_cpu = 0, mode_cpu = 0;
  logic [2:0] cfg_idx = 0;
  logic [7:0] cfg_blk = 0;
  logic [NC-1:0] req_valid = 0, req_write = 0;
  logic [NC*LW-1:0] req_addr = '0;
  logic [NC-1:0] phy_valid, phy_write, fault;
  logic [NC*PW-1:0] phy_addr;

  always #4 clk = ~clk;

  bank_mmu u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_cpu(cfg_cpu), .cfg_ext(cfg_ext),
    .cfg_idx(cfg_idx), .cfg_blk(cfg_blk), .mode_we(mode_we), .mode_cpu(mode_cpu),
    .mode_ext(mode_ext), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .phy_valid(phy_valid), .phy_write(phy_write),
    .phy_addr(phy_addr), .fault(fault)
  );

  // reference state
  int m_std [NC][8];
  int m_ext [NC][8];
  int m_mode [NC];
  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  function automatic int sb_base(int c, int q);
    int tbl [4][4] = '{'{0,1,2,3}, '{4,5,1,3}, '{6,5,7,3}, '{8,7,2,3}};
    return tbl[c][q];
  endfunction

  function automatic int model_pa(int c, int a);
    int b;
    if (m_mode[c] != 0 && a >= 32768) begin
      if (c == 0) return m_ext[0][4] * 32768 + a % 32768;
      return m_ext[1][4 + (a / 16384) % 2] * 16384 + a % 16384;
    end
    b = (m_mode[c] != 0) ? m_ext[c][a / 8192] : m_std[c][a / 8192];
    return sb_base(c, b / 64) * 524288 + (b % 64) * 8192 + a % 8192;
  endfunction

  task automatic model_reset();
    for (int c = 0; c < NC; c++) begin
      for (int n = 0; n < 8; n++) begin
        m_std[c][n] = 56 + n;
        m_ext[c][n] = 0;
      end
      m_mode[c] = 0;
    end
  endtask

  // one clock: predict, clock, update model, compare
  task automatic step(string tag);
    int ev [NC]; int ew [NC]; int ef [NC]; int ea [NC];
    for (int c = 0; c < NC; c++) begin
      int a;
      a     = int'(req_addr[c*LW +: LW]);
      ea[c] = model_pa(c, a);
      ev[c] = int'(req_valid[c]);
      ef[c] = (req_valid[c] && req_write[c] && c != 0 && ea[c] / 8192 == 255) ? 1 : 0;
      ew[c] = (req_valid[c] && req_write[c] && ef[c] == 0) ? 1 : 0;
    end
    @(posedge clk);
    if (cfg_we) begin
      if (!cfg_ext) m_std[cfg_cpu][cfg_idx] = int'(cfg_blk);
      else if ((cfg_cpu == 0 && cfg_idx < 5) || (cfg_cpu == 1 && cfg_idx < 6))
        m_ext[cfg_cpu][cfg_idx] = int'(cfg_blk);
    end
    if (mode_we && mode_cpu < 2) m_mode[mode_cpu] = int'(mode_ext);
    @(negedge clk);
    vectors++;
    for (int c = 0; c < NC; c++) begin
      if (int'(phy_valid[c]) != ev[c]) begin
        errors++;
        $display("FAIL %s cpu%0d valid: actual %0d expected %0d", tag, c, phy_valid[c], ev[c]);
      end
      if (int'(phy_write[c]) != ew[c] || int'(fault[c]) != ef[c]) begin
        errors++;
        $display("FAIL %s cpu%0d write/fault: actual %0d/%0d expected %0d/%0d",
                 tag, c, phy_write[c], fault[c], ew[c], ef[c]);
      end
      if (ev[c] != 0 && int'(phy_addr[c*PW +: PW]) != ea[c]) begin
        errors++;
        $display("FAIL %s cpu%0d addr: actual %h expected %h", tag, c, phy_addr[c*PW +: PW], ea[c]);
      end
    end
  endtask

  task automatic idle_in();
    cfg_we = 0; mode_we = 0; req_valid = '0; req_write = '0;
  endtask

  task automatic cfg(int c, int ext, int idx, int blk, string tag);
    idle_in();
    cfg_we = 1; cfg_cpu = 2'(c); cfg_ext = ext[0]; cfg_idx = 3'(idx); cfg_blk = 8'(blk);
    step(tag);
    cfg_we = 0;
  endtask

  task automatic set_mode(int c, int ext, string tag);
    idle_in();
    mode_we = 1; mode_cpu = 2'(c); mode_ext = ext[0];
    step(tag);
    mode_we = 0;
  endtask

  task automatic req(int c, int wr, int a);
    req_valid[c] = 1'b1;
    req_write[c] = wr[0];
    req_addr[c*LW +: LW] = LW'(a);
  endtask

  task automatic all_read(int a, string tag);
    idle_in();
    for (int c = 0; c < NC; c++) req(c, 0, a);
    step(tag);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;

    // R1: idle outputs and reset bank contents
    step("R1");
    all_read(16'h0000, "R1");
    all_read(16'h2345, "R1");
    all_read(16'hE001, "R1");

    // R2: program every standard register, sweep windows
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < 8; w++)
        cfg(c, 0, w, (c * 37 + w * 29 + 11) % 256, "R2");
    for (int w = 0; w < 8; w++) all_read(w * 8192 + w * 333, "R2");

    // R3: shared quadrant gives identical addresses
    for (int c = 0; c < NC; c++) cfg(c, 0, 0, 200, "R3");
    all_read(16'h0100, "R3");
    for (int c = 1; c < NC; c++)
      if (phy_addr[c*PW +: PW] != phy_addr[0 +: PW]) begin
        errors++;
        $display("FAIL R3 cpu%0d addr: actual %h expected %h", c, phy_addr[c*PW +: PW], phy_addr[0 +: PW]);
      end

    // R4: guarded page
    for (int c = 0; c < NC; c++) cfg(c, 0, 2, 255, "R4");
    idle_in();
    for (int c = 0; c < NC; c++) req(c, 1, 16'h4010);
    step("R4");
    step("R4");
    all_read(16'h4010, "R4");
    idle_in(); req(2, 1, 16'h5FFF); req(0, 1, 16'h0000); step("R4");

    // R9: same-edge config does not touch the concurrent request
    idle_in();
    cfg_we = 1; cfg_cpu = 2; cfg_ext = 0; cfg_idx = 0; cfg_blk = 10;
    req(2, 0, 16'h0004);
    step("R9");
    idle_in(); req(2, 0, 16'h0004); step("R9");

    // R5: CPU0 extended
    cfg(0, 1, 0, 1, "R5");
    cfg(0, 1, 4, 200, "R5");
    set_mode(0, 1, "R5");
    idle_in(); req(0, 0, 16'h0007); step("R5");
    idle_in(); req(0, 0, 16'h9000); step("R5");
    idle_in(); req(0, 1, 16'hFFFF); step("R5");

    // R7: mode swap keeps both sets
    set_mode(0, 0, "R7");
    idle_in(); req(0, 0, 16'h0007); req(1, 0, 16'h0007); step("R7");
    cfg(0, 0, 4, 9, "R7");
    set_mode(0, 1, "R7");
    idle_in(); req(0, 0, 16'h8123); step("R7");

    // R6: CPU1 extended with two high windows
    cfg(1, 1, 4, 3, "R6");
    cfg(1, 1, 5, 127, "R6");
    cfg(1, 1, 1, 250, "R6");
    set_mode(1, 1, "R6");
    idle_in(); req(1, 0, 16'h8001); step("R6");
    idle_in(); req(1, 0, 16'hC002); step("R6");
    idle_in(); req(1, 0, 16'h2002); step("R6");
    idle_in(); req(1, 1, 16'hE000); step("R6");
    idle_in(); req(1, 1, 16'hC000); step("R6");

    // R8: CPU2/3 cannot enter extended mode
    set_mode(2, 1, "R8");
    set_mode(3, 1, "R8");
    idle_in(); req(2, 0, 16'hA000); req(3, 0, 16'hF00F); step("R8");

    // R10: mixed valid/write patterns
    for (int k = 0; k < 16; k++) begin
      idle_in();
      for (int c = 0; c < NC; c++)
        if (((k >> c) & 1) != 0) req(c, (k + c) % 2, (k * 4099 + c * 777) % 65536);
      step("R10");
    end
    idle_in(); step("R10");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule